// File: doc/BRIEF.md
# Debug abstract command sequencer

This block sits between a debugger-facing register port and one hart. The debugger writes a command word. The block decodes it into a register number, a direction, an access size, a transfer-enable bit and a post-execute request. It then runs a fixed sequence. If the transfer bit is set, it first moves one hart register into, or out of, the argument data registers. If post-execute is requested, it then fires one program-buffer run and waits for that run to finish.

The debugger watches a control/status word. That word carries a busy flag, a three-bit error code and the number of argument data words. The block has two handshakes on the hart side:
- a request/acknowledge port for register access, which stays asserted until the hart acknowledges;
- a start pulse and done strobe for the program buffer.

Quick-access commands, auto-execution and the program-buffer storage are outside this block. `XLEN` sets the largest register width and the number of 32-bit argument words (`XLEN/32`). `HAS_FPR` decides whether floating-point register numbers are accepted.

Top module: `dbg_acmd_seq`

## Requirements
- R1: After reset the sequencer is idle. Every data word reads 0, the status word reads busy=0 and error=0, and status bits 3:0 report `XLEN/32`. No hart request and no program-buffer start are driven.
- R2: A command whose type field (bits 31:24) is nonzero is not executed. It sets the error code (status bits 10:8) to 2 and leaves busy at 0.
- R3: When the transfer bit is 1, bits 23:20 are taken as the size code. Code 2 (low 32 bits) is always accepted. Code 3 (low 64 bits) is accepted only when `XLEN` is 64. Every other code, and any command with bit 19 set, is rejected with error 3. Register numbers are accepted in these ranges:
  - 0x0000–0x0FFF (CSRs);
  - 0x1000–0x101F (general registers);
  - 0x1020–0x103F (floating-point registers), only when `HAS_FPR` is nonzero.

  Any other register number, including 0xC000 and above, gives error 3.
- R4: A transfer with bit 16 = 0 holds `hreg_req` with `hreg_write`=0 and a stable `hreg_regno` until `hreg_ack`. On the acknowledge edge, `hreg_rdata` is copied into data0, and also into data1 when the size code is 3.
- R5: A transfer with bit 16 = 1 drives `hreg_write`=1. `hreg_wdata` is {data1,data0} for size code 3, and data0 zero-extended for size code 2.
- R6: With transfer bit 17 = 0, no hart request is made and the size and register fields are not checked. If post-execute is also 0, the command does nothing and busy stays 0.
- R7: With post-execute bit 18 = 1, exactly one single-cycle `pb_start` pulse follows the transfer (or follows acceptance, when there is no transfer). The command then stays busy until `pb_done`.
- R8: Status bit 12 (busy) is 1 from the edge that accepts a command until the edge that completes its last step.
- R9: A command written while busy is ignored. It sets the error code to 1 if the code was 0.
- R10: While the error code is nonzero, command writes are ignored. A write to the status word clears exactly the error bits written as 1 in bits 10:8.
- R11: Writes to data registers while busy are ignored.
- R12: The status word is at 0x16, the command at 0x17 (reads back 0), and data word i at 0x04+i. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_addr | input | 7 | Debugger register address (read and write) |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Read data for `dbg_addr`, combinational |
| hreg_req | output | 1 | Hart register access request, held until acknowledged |
| hreg_write | output | 1 | 1 = write the hart register, 0 = read it |
| hreg_regno | output | 16 | Hart register number |
| hreg_size | output | 3 | Access size code |
| hreg_wdata | output | XLEN | Data for a hart register write |
| hreg_ack | input | 1 | Hart acknowledges the access |
| hreg_rdata | input | XLEN | Hart register value, valid with `hreg_ack` |
| pb_start | output | 1 | One-cycle pulse that starts the program buffer |
| pb_done | input | 1 | Program buffer run finished |

## Verification
The bench builds the block with `XLEN`=64 and `HAS_FPR`=0. This makes two-word moves with size code 3 possible. It also makes the floating-point register range a rejected range, so the error-3 path can be reached through a register number that the default build would accept. The bench varies the hart acknowledge latency and the program-buffer run time. This puts command and data writes into the middle of a busy sequence, and lets the error-blocking and selective clearing be exercised between runs.

// File: rtl/dbg_acmd_pkg.sv
package dbg_acmd_pkg;

    localparam logic [6:0] A_DATA_BASE = 7'h04;
    localparam logic [6:0] A_CTRL      = 7'h16;
    localparam logic [6:0] A_CMD       = 7'h17;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUSY = 3'd1;
    localparam logic [2:0] ERR_TYPE = 3'd2;
    localparam logic [2:0] ERR_ARG  = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_PB_GO,
        ST_PB_WAIT
    } seq_state_e;

    // Packed view of a command word, most significant field first.
    typedef struct packed {
        logic [7:0]  ctype;
        logic [3:0]  size;
        logic        rsv;
        logic        postexec;
        logic        transfer;
        logic        write;
        logic [15:0] regno;
    } acmd_t;

    function automatic logic size_ok(input logic [3:0] sz, input int xlen);
        return (sz == 4'd2) || (sz == 4'd3 && xlen >= 64);
    endfunction

    function automatic logic regno_ok(input logic [15:0] r, input logic fpr);
        logic csr_hit, gpr_hit, fpr_hit;
        csr_hit = (r < 16'h1000);
        gpr_hit = (r >= 16'h1000) && (r <= 16'h101F);
        fpr_hit = fpr && (r >= 16'h1020) && (r <= 16'h103F);
        return csr_hit || gpr_hit || fpr_hit;
    endfunction

    // Number of 32-bit argument words a size code moves.
    function automatic int size_words(input logic [2:0] sz);
        return (sz == 3'd3) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dbg_acmd_check.sv
module dbg_acmd_check
    import dbg_acmd_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int HAS_FPR = 1
) (
    input  logic [31:0] cmd_word,
    output logic        o_xfer,
    output logic        o_post,
    output logic        o_write,
    output logic [2:0]  o_size,
    output logic [15:0] o_regno,
    output logic [2:0]  o_err
);
    localparam logic FPR_EN = (HAS_FPR != 0);

    acmd_t c;

    always_comb begin
        c       = acmd_t'(cmd_word);
        o_xfer  = c.transfer;
        o_post  = c.postexec;
        o_write = c.write;
        o_size  = c.size[2:0];
        o_regno = c.regno;
        if (c.ctype != 8'd0) begin
            o_err = ERR_TYPE;
        end else if (c.transfer &&
                     (!size_ok(c.size, XLEN) || c.rsv || !regno_ok(c.regno, FPR_EN))) begin
            o_err = ERR_ARG;
        end else begin
            o_err = ERR_NONE;
        end
    end
endmodule

// File: rtl/dbg_acmd_fsm.sv
module dbg_acmd_fsm
    import dbg_acmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        start_xfer,
    input  logic        start_post,
    input  logic        start_write,
    input  logic [2:0]  start_size,
    input  logic [15:0] start_regno,
    input  logic        hreg_ack,
    input  logic        pb_done,
    output logic        busy,
    output logic        hreg_req,
    output logic        hreg_write,
    output logic [15:0] hreg_regno,
    output logic [2:0]  hreg_size,
    output logic        cap_en,
    output logic        pb_start
);
    seq_state_e  state_q;
    logic        post_q;
    logic        write_q;
    logic [2:0]  size_q;
    logic [15:0] regno_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            post_q  <= 1'b0;
            write_q <= 1'b0;
            size_q  <= '0;
            regno_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        post_q  <= start_post;
                        write_q <= start_write;
                        size_q  <= start_size;
                        regno_q <= start_regno;
                        state_q <= start_xfer ? ST_XFER : ST_PB_GO;
                    end
                end
                ST_XFER: begin
                    if (hreg_ack) state_q <= post_q ? ST_PB_GO : ST_IDLE;
                end
                ST_PB_GO:   state_q <= ST_PB_WAIT;
                ST_PB_WAIT: begin
                    if (pb_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        hreg_req   = (state_q == ST_XFER);
        hreg_write = write_q;
        hreg_regno = regno_q;
        hreg_size  = size_q;
        cap_en     = (state_q == ST_XFER) && hreg_ack && !write_q;
        pb_start   = (state_q == ST_PB_GO);
    end

    assert_pb_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        pb_start |=> !pb_start);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (hreg_req && !hreg_ack) |=> (hreg_req && $stable(hreg_regno) && $stable(hreg_write)));

    assert_pb_wait_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (pb_start) |=> busy);
endmodule

// File: rtl/dbg_acmd_args.sv
module dbg_acmd_args
    import dbg_acmd_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NWORDS = XLEN / 32,
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic             busy,
    input  logic             cap_en,
    input  logic [2:0]       size,
    input  logic [XLEN-1:0]  cap_data,
    output logic [XLEN-1:0]  data_q,
    output logic [XLEN-1:0]  xfer_wdata
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w);

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[w*32 +: 32] <= '0;
            end else if (cap_en && (w < size_words(size))) begin
                data_q[w*32 +: 32] <= cap_data[w*32 +: 32];
            end else if (wr_en && !busy && wr_idx == MY_IDX) begin
                data_q[w*32 +: 32] <= wr_data;
            end
        end

        assign xfer_wdata[w*32 +: 32] = (w < size_words(size)) ? data_q[w*32 +: 32] : 32'd0;
    end

    assert_data_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !cap_en) |=> $stable(data_q));
endmodule

// File: rtl/dbg_acmd_seq.sv
module dbg_acmd_seq
    import dbg_acmd_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int HAS_FPR = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dbg_wr,
    input  logic [6:0]      dbg_addr,
    input  logic [31:0]     dbg_wdata,
    output logic [31:0]     dbg_rdata,
    output logic            hreg_req,
    output logic            hreg_write,
    output logic [15:0]     hreg_regno,
    output logic [2:0]      hreg_size,
    output logic [XLEN-1:0] hreg_wdata,
    input  logic            hreg_ack,
    input  logic [XLEN-1:0] hreg_rdata,
    output logic            pb_start,
    input  logic            pb_done
);
    localparam int NWORDS = XLEN / 32;
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [6:0] A_DATA_END = A_DATA_BASE + 7'(NWORDS);

    logic            busy;
    logic [2:0]      err_q;
    logic            cmd_wr, cs_wr, data_wr, data_hit;
    logic [IDX_W-1:0] wr_idx;
    logic            c_xfer, c_post, c_write;
    logic [2:0]      c_size;
    logic [15:0]     c_regno;
    logic [2:0]      c_err;
    logic            start;
    logic            cap_en;
    logic [XLEN-1:0] data_q;

    assign data_hit = (dbg_addr >= A_DATA_BASE) && (dbg_addr < A_DATA_END);
    assign cmd_wr   = dbg_wr && (dbg_addr == A_CMD);
    assign cs_wr    = dbg_wr && (dbg_addr == A_CTRL);
    assign data_wr  = dbg_wr && data_hit;
    assign wr_idx   = IDX_W'(dbg_addr - A_DATA_BASE);

    dbg_acmd_check #(.XLEN(XLEN), .HAS_FPR(HAS_FPR)) u_check (
        .cmd_word (dbg_wdata),
        .o_xfer   (c_xfer),
        .o_post   (c_post),
        .o_write  (c_write),
        .o_size   (c_size),
        .o_regno  (c_regno),
        .o_err    (c_err)
    );

    assign start = cmd_wr && !busy && (err_q == ERR_NONE) && (c_err == ERR_NONE)
                   && (c_xfer || c_post);

    dbg_acmd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_xfer  (c_xfer),
        .start_post  (c_post),
        .start_write (c_write),
        .start_size  (c_size),
        .start_regno (c_regno),
        .hreg_ack    (hreg_ack),
        .pb_done     (pb_done),
        .busy        (busy),
        .hreg_req    (hreg_req),
        .hreg_write  (hreg_write),
        .hreg_regno  (hreg_regno),
        .hreg_size   (hreg_size),
        .cap_en      (cap_en),
        .pb_start    (pb_start)
    );

    dbg_acmd_args #(.XLEN(XLEN)) u_args (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (data_wr),
        .wr_idx     (wr_idx),
        .wr_data    (dbg_wdata),
        .busy       (busy),
        .cap_en     (cap_en),
        .size       (hreg_size),
        .cap_data   (hreg_rdata),
        .data_q     (data_q),
        .xfer_wdata (hreg_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= ERR_NONE;
        end else if (cs_wr) begin
            err_q <= err_q & ~dbg_wdata[10:8];
        end else if (cmd_wr) begin
            if (busy) begin
                if (err_q == ERR_NONE) err_q <= ERR_BUSY;
            end else if (err_q == ERR_NONE && c_err != ERR_NONE) begin
                err_q <= c_err;
            end
        end
    end

    always_comb begin
        dbg_rdata = 32'd0;
        if (dbg_addr == A_CTRL) begin
            dbg_rdata = {19'd0, busy, 1'b0, err_q, 4'd0, 4'(NWORDS)};
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                if (dbg_addr == A_DATA_BASE + 7'(w)) dbg_rdata = data_q[w*32 +: 32];
            end
        end
    end

    assert_type_reject_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && err_q == ERR_NONE && dbg_wdata[31:24] != 8'd0)
        |=> (err_q == ERR_TYPE && !busy));

    assert_busy_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> (err_q != ERR_NONE));

    assert_err_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !busy && err_q != ERR_NONE) |=> (!busy && err_q == $past(err_q)));
endmodule

// File: tb/dbg_acmd_seq_test.sv
module dbg_acmd_seq_test;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        dbg_wr = 1'b0;
    logic [6:0]  dbg_addr = 7'h16;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic        hreg_req, hreg_write, pb_start;
    logic [15:0] hreg_regno;
    logic [2:0]  hreg_size;
    logic [63:0] hreg_wdata;
    logic        hreg_ack = 1'b0;
    logic [63:0] hreg_rdata = '0;
    logic        pb_done = 1'b0;

    dbg_acmd_seq #(.XLEN(XLEN), .HAS_FPR(0)) uut (
        .clk(clk), .rst(rst), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .hreg_req(hreg_req),
        .hreg_write(hreg_write), .hreg_regno(hreg_regno), .hreg_size(hreg_size),
        .hreg_wdata(hreg_wdata), .hreg_ack(hreg_ack), .hreg_rdata(hreg_rdata),
        .pb_start(pb_start), .pb_done(pb_done)
    );

    int compared = 0, mismatched = 0, cycles = 0;
    bit finished = 0;
    string ctx = "R1";

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- hart and program buffer models ----------------
    logic [63:0] hregs [0:127];
    int hlat = 0, hcnt = 0, hacks = 0;
    int pblat = 1, pbcnt = 0, pb_starts = 0;

    function automatic int hidx(input logic [15:0] r);
        return (r >= 16'h1000) ? int'(r[5:0]) : 64 + int'(r[5:0]);
    endfunction

    always @(posedge clk) begin
        #1;
        if (!rst && hreg_req) begin
            if (hcnt >= hlat) begin
                hreg_ack = 1'b1;
                hacks++;
                hreg_rdata = hregs[hidx(hreg_regno)];
                if (hreg_write) hregs[hidx(hreg_regno)] = hreg_wdata;
                hcnt = 0;
            end else begin
                hreg_ack = 1'b0;
                hcnt++;
            end
        end else begin
            hreg_ack = 1'b0;
            hcnt = 0;
        end
        if (!rst && pb_start) begin
            pb_starts++;
            pbcnt = pblat;
            pb_done = 1'b0;
        end else if (pbcnt > 0) begin
            pbcnt--;
            pb_done = (pbcnt == 0);
        end else begin
            pb_done = 1'b0;
        end
    end

    // ---------------- reference model ----------------
    int          m_ph;          // 0 idle, 1 moving, 2 launching, 3 running
    logic [2:0]  m_err;
    logic [31:0] m_d0, m_d1;
    logic        m_post, m_wr;
    logic [2:0]  m_sz;
    logic [15:0] m_rn;
    bit          was_busy;

    function automatic bit bad_args(input logic [31:0] w);
        logic [3:0] sz;
        sz = w[23:20];
        return !(sz == 4'd2 || sz == 4'd3) || w[19] || (w[15:0] > 16'h101F);
    endfunction

    function automatic logic [31:0] mread(input logic [6:0] a);
        case (a)
            7'h16:   return {19'd0, (m_ph != 0), 1'b0, m_err, 4'd0, 4'd2};
            7'h04:   return m_d0;
            7'h05:   return m_d1;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_err = 0; m_d0 = 0; m_d1 = 0;
            m_post = 0; m_wr = 0; m_sz = 0; m_rn = 0;
        end else begin
            was_busy = (m_ph != 0);
            case (m_ph)
                1: if (hreg_ack) begin
                       if (!m_wr) begin
                           m_d0 = hreg_rdata[31:0];
                           if (m_sz == 3'd3) m_d1 = hreg_rdata[63:32];
                       end
                       m_ph = m_post ? 2 : 0;
                   end
                2: m_ph = 3;
                3: if (pb_done) m_ph = 0;
                default: ;
            endcase
            if (dbg_wr) begin
                if (dbg_addr == 7'h16) m_err = m_err & ~dbg_wdata[10:8];
                else if (dbg_addr == 7'h04 && !was_busy) m_d0 = dbg_wdata;
                else if (dbg_addr == 7'h05 && !was_busy) m_d1 = dbg_wdata;
                else if (dbg_addr == 7'h17) begin
                    if (was_busy) begin
                        if (m_err == 0) m_err = 3'd1;
                    end else if (m_err == 0) begin
                        if (dbg_wdata[31:24] != 0) m_err = 3'd2;
                        else if (dbg_wdata[17] && bad_args(dbg_wdata)) m_err = 3'd3;
                        else begin
                            m_post = dbg_wdata[18];
                            m_wr   = dbg_wdata[16];
                            m_sz   = dbg_wdata[22:20];
                            m_rn   = dbg_wdata[15:0];
                            if (dbg_wdata[17]) m_ph = 1;
                            else if (dbg_wdata[18]) m_ph = 2;
                        end
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!rst && !finished) begin
            chk(ctx, "dbg_rdata", 64'(dbg_rdata), 64'(mread(dbg_addr)));
            chk(ctx, "hreg_req", 64'(hreg_req), 64'(m_ph == 1));
            chk(ctx, "pb_start", 64'(pb_start), 64'(m_ph == 2));
            if (m_ph == 1) begin
                chk(ctx, "hreg_regno", 64'(hreg_regno), 64'(m_rn));
                chk(ctx, "hreg_write", 64'(hreg_write), 64'(m_wr));
                chk(ctx, "hreg_size", 64'(hreg_size), 64'(m_sz));
                if (m_wr)
                    chk(ctx, "hreg_wdata", hreg_wdata,
                        (m_sz == 3'd3) ? {m_d1, m_d0} : {32'd0, m_d0});
            end
        end
        if (cycles > 50000 && !finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] mkcmd(input logic [7:0] t, input logic [2:0] sz,
                                          input logic post, input logic xfer,
                                          input logic wr, input logic [15:0] rn);
        return {t, 1'b0, sz, 1'b0, post, xfer, wr, rn};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        dbg_wr = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #1;
        dbg_wr = 1'b0; dbg_addr = 7'h16;
    endtask

    task automatic expect_rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        dbg_addr = a;
        @(negedge clk);
        chk(tag, "readback", 64'(dbg_rdata), 64'(exp));
    endtask

    task automatic wait_done();
        do @(negedge clk); while (m_ph != 0);
    endtask

    logic [3:0]  bsz [0:6] = '{4'd4, 4'd1, 4'd3, 4'd2, 4'd2, 4'd2, 4'd2};
    logic [15:0] brn [0:6] = '{16'h1000, 16'h1000, 16'h1020, 16'h103F, 16'hC000, 16'h1040, 16'h1001};

    initial begin
        for (int i = 0; i < 128; i++) hregs[i] = {32'hC0DE0000 + 32'(i), 32'h0BAD0000 + 32'(i)};
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        ctx = "R1";
        @(negedge clk);
        chk("R1", "hreg_req", 64'(hreg_req), 64'd0);
        chk("R1", "pb_start", 64'(pb_start), 64'd0);
        expect_rd(7'h16, 32'h0000_0002, "R1");
        expect_rd(7'h04, 32'd0, "R1");
        expect_rd(7'h05, 32'd0, "R1");

        // R12: address map
        ctx = "R12";
        wr(7'h04, 32'hA5A5_0001);
        wr(7'h05, 32'h5A5A_0002);
        expect_rd(7'h04, 32'hA5A5_0001, "R12");
        expect_rd(7'h05, 32'h5A5A_0002, "R12");
        expect_rd(7'h17, 32'd0, "R12");
        expect_rd(7'h06, 32'd0, "R12");
        expect_rd(7'h10, 32'd0, "R12");

        // R4: reads with two latencies, two sizes
        ctx = "R4";
        hlat = 0;
        wr(7'h17, mkcmd(8'd0, 3'd3, 1'b0, 1'b1, 1'b0, 16'h1005));
        wait_done();
        hlat = 3;
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h07B1));
        wait_done();
        expect_rd(7'h04, 32'h0BAD0071, "R4");
        expect_rd(7'h05, 32'hC0DE0005, "R4");

        // R5: writes, full width and zero-extended
        ctx = "R5";
        wr(7'h04, 32'h1111_2222);
        wr(7'h05, 32'h3333_4444);
        wr(7'h17, mkcmd(8'd0, 3'd3, 1'b0, 1'b1, 1'b1, 16'h1010));
        wait_done();
        chk("R5", "hart gpr16", hregs[16], 64'h3333_4444_1111_2222);
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b1, 16'h1011));
        wait_done();
        chk("R5", "hart gpr17", hregs[17], 64'h0000_0000_1111_2222);

        // R7: transfer then one program buffer run
        ctx = "R7";
        hlat = 1; pblat = 4; pb_starts = 0;
        wr(7'h17, mkcmd(8'd0, 3'd3, 1'b1, 1'b1, 1'b0, 16'h1010));
        wait_done();
        chk("R7", "pb_start count", 64'(pb_starts), 64'd1);
        expect_rd(7'h05, 32'h3333_4444, "R7");

        // R6: no transfer; garbage size and number are not checked
        ctx = "R6";
        pb_starts = 0; hacks = 0;
        wr(7'h17, mkcmd(8'd0, 3'd7, 1'b1, 1'b0, 1'b0, 16'hFFFF));
        wait_done();
        chk("R6", "pb_start count", 64'(pb_starts), 64'd1);
        chk("R6", "hart accesses", 64'(hacks), 64'd0);
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b0, 1'b0, 16'h1000));
        expect_rd(7'h16, 32'h0000_0002, "R6");
        chk("R6", "hart accesses", 64'(hacks), 64'd0);

        // R8: busy during a slow access
        ctx = "R8";
        hlat = 4;
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1002));
        expect_rd(7'h16, 32'h0000_1002, "R8");
        wait_done();
        expect_rd(7'h16, 32'h0000_0002, "R8");

        // R9 / R11: writes landing while busy
        ctx = "R11";
        hlat = 6; pblat = 5;
        wr(7'h04, 32'hDEAD_0000);
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 16'h1012));
        wr(7'h04, 32'hFFFF_FFFF);
        ctx = "R9";
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1003));
        wait_done();
        expect_rd(7'h16, 32'h0000_0102, "R9");
        expect_rd(7'h04, 32'hDEAD_0000, "R11");
        chk("R11", "hart gpr18", hregs[18], 64'h0000_0000_DEAD_0000);

        // R10: error blocks commands; selective clear
        ctx = "R10";
        hlat = 0;
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1001));
        expect_rd(7'h16, 32'h0000_0102, "R10");
        wr(7'h16, 32'h0000_0200);
        expect_rd(7'h16, 32'h0000_0102, "R10");
        wr(7'h16, 32'h0000_0700);
        expect_rd(7'h16, 32'h0000_0002, "R10");
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1001));
        wait_done();
        expect_rd(7'h04, 32'h0BAD_0001, "R10");

        // R2: unsupported command type
        ctx = "R2";
        wr(7'h17, mkcmd(8'd1, 3'd2, 1'b0, 1'b1, 1'b0, 16'h1001));
        expect_rd(7'h16, 32'h0000_0202, "R2");
        wr(7'h16, 32'h0000_0700);

        // R3: argument checks
        ctx = "R3";
        for (int i = 0; i < 7; i++) begin
            wr(7'h17, {8'd0, bsz[i], 1'b0, 1'b0, 1'b1, 1'b0, brn[i]} | ((i == 6) ? 32'h0008_0000 : 32'd0));
            expect_rd(7'h16, 32'h0000_0302, "R3");
            wr(7'h16, 32'h0000_0700);
        end
        wr(7'h17, mkcmd(8'd0, 3'd3, 1'b0, 1'b1, 1'b0, 16'h101F));
        wait_done();
        expect_rd(7'h16, 32'h0000_0002, "R3");
        wr(7'h17, mkcmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0FFF));
        wait_done();
        expect_rd(7'h16, 32'h0000_0002, "R3");
        expect_rd(7'h05, 32'hC0DE_001F, "R3");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule